// File: doc/BRIEF.md
# Two-Channel DMA Engine

This block moves data on behalf of a processor, either from one memory range to another or between memory and a peripheral, without the processor touching each unit. It has two channels with the same capability. Software sets a channel's source address, destination address, byte count and control word through a small register port. The engine then asks for the system bus with a request/grant handshake and issues the bus cycles itself.

Each channel moves byte, half-word or word units. In dual-address mode a unit is a read at the source followed by a write of the same data at the destination. In single-address (fly-by) mode a unit is one bus cycle. The peripheral takes or supplies the data directly, strobed by the channel's acknowledge line. A channel starts either when it is enabled (auto-request) or while its peripheral request line is high. In burst mode it keeps the bus until its count is used up. In cycle-steal mode it gives the bus back after every unit. A global bit picks which channel wins when both are ready. When a channel's count runs out it clears its enable, sets a done flag and raises its interrupt.

Top module: `dma2_top`

## Requirements
- R1: After reset, bus_req, bus_valid, dack and irq are low, and the global status register (offset 4) reads 0.
- R2: Register offsets are reg_addr = {channel, field}. Field 0 is the source address, 1 the destination address, 2 the byte count (19 bits, so 0x40000 reads back intact) and 3 the control word. Control bits: [0] enable, [2:1] unit (0 byte, 1 half-word, 2 word), [3] burst, [4] single-address, [5] auto-request, [6] fly-by direction. Field 4 is global: bit 0 is the priority select, [9:8] are the done flags and [11:10] the error flags of channels 0 and 1.
- R3: In dual-address mode every unit is a read at the current source address (bus_write=0), followed in the next cycle by a write (bus_write=1) of the read data at the current destination address.
- R4: After each unit both addresses advance, and the count drops, by 1, 2 or 4 bytes for unit code 0, 1 or 2, and bus_size carries the unit code.
- R5: In single-address mode each unit is one bus cycle. With direction 0 it is a read at the source address, with direction 1 a write at the destination address, and the channel's dack is high in that cycle.
- R6: In burst mode bus_req stays high from the grant until the channel's last unit, so a whole transfer shows one falling edge of bus_req.
- R7: In cycle-steal mode bus_req drops in the cycle after every unit, and the next unit arbitrates again.
- R8: With auto-request clear, an enabled channel issues no bus request while its dreq is low, and it transfers once dreq goes high.
- R9: When both channels are ready at an arbitration point, channel 0 wins if priority bit 0 is 0 and channel 1 wins if it is 1.
- R10: After a channel's last unit, its enable reads 0, its done flag and irq go high, and writing 1 to its done bit clears both.
- R11: Enabling a channel with a source or destination address, or a count, that is not a multiple of the unit size, or with a count of 0 or above 0x40000, sets its error flag (which writing 1 clears). The enable reads 0 and no bus request follows.
- R12: At most one dack bit is high at a time, and only in a bus cycle of that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset {channel, field} |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant |
| bus_valid | output | 1 | Bus cycle in progress this clock |
| bus_write | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr | output | 32 | Bus address |
| bus_size | output | 2 | Unit code of the cycle |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid in a read cycle |
| dreq | input | 2 | Peripheral request per channel |
| dack | output | 2 | Peripheral acknowledge per channel |
| irq | output | 2 | Completion interrupt per channel |

## Verification
The checker watches on every cycle that the acknowledge lines stay one-hot and only mark real bus cycles, and that word and half-word cycles are aligned. It also watches that a burst keeps its request across units while cycle-steal drops it after each unit, and that an interrupt rises only just after a unit ends. The order and content of bus cycles can only be shown by the bench's scenarios: read-then-write pairs, address stepping per unit size, fly-by direction, the winner under each priority setting, the blocking effect of a low dreq, and the refusal of bad setups. The bench predicts each expected cycle and compares it against what the engine issues.

// File: rtl/dma2_pkg.sv
package dma2_pkg;
    localparam int AW  = 32;
    localparam int DW  = 32;
    localparam int CW  = 19;
    localparam int NCH = 2;
    localparam logic [CW-1:0] MAX_BYTES = 19'h40000;

    typedef enum logic [1:0] {
        UNIT_B = 2'd0,
        UNIT_H = 2'd1,
        UNIT_W = 2'd2,
        UNIT_X = 2'd3
    } unit_e;

    typedef struct packed {
        logic  dir;
        logic  autoreq;
        logic  single;
        logic  burst;
        unit_e unit;
        logic  en;
    } ctrl_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_RD,
        ST_WR,
        ST_ONE
    } st_e;

    function automatic logic [CW-1:0] unit_bytes(unit_e u);
        case (u)
            UNIT_H:  return CW'(2);
            UNIT_W:  return CW'(4);
            default: return CW'(1);
        endcase
    endfunction

    function automatic logic misaligned(unit_e u, logic [1:0] low);
        case (u)
            UNIT_H:  return low[0];
            UNIT_W:  return |low;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic bad_setup(unit_e u, logic [1:0] s_lo, logic [1:0] d_lo,
                                       logic [CW-1:0] cnt);
        return (u == UNIT_X) || misaligned(u, s_lo) || misaligned(u, d_lo)
            || misaligned(u, cnt[1:0]) || (cnt == '0) || (cnt > MAX_BYTES);
    endfunction
endpackage

// File: rtl/dma2_chan.sv
module dma2_chan
    import dma2_pkg::*;
#(
    parameter int A_W = AW,
    parameter int C_W = CW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_src,
    input  logic           wr_dst,
    input  logic           wr_cnt,
    input  logic           wr_ctrl,
    input  logic [DW-1:0]  wdata,
    input  logic           clr_done,
    input  logic           clr_err,
    input  logic           dreq,
    input  logic           step,
    output logic [A_W-1:0] src,
    output logic [A_W-1:0] dst,
    output logic [C_W-1:0] cnt,
    output ctrl_t          ctrl,
    output logic           ready,
    output logic           last,
    output logic           done,
    output logic           err
);
    ctrl_t          wctrl;
    logic [C_W-1:0] sz;

    assign wctrl = ctrl_t'(wdata[$bits(ctrl_t)-1:0]);
    assign sz    = unit_bytes(ctrl.unit);
    assign last  = (cnt == sz);
    assign ready = ctrl.en && (ctrl.autoreq || dreq);

    always_ff @(posedge clk) begin
        if (rst) begin
            src  <= '0;
            dst  <= '0;
            cnt  <= '0;
            ctrl <= '0;
            done <= 1'b0;
            err  <= 1'b0;
        end else begin
            if (clr_done) done <= 1'b0;
            if (clr_err)  err  <= 1'b0;
            if (wr_src)   src  <= wdata[A_W-1:0];
            if (wr_dst)   dst  <= wdata[A_W-1:0];
            if (wr_cnt)   cnt  <= wdata[C_W-1:0];
            if (wr_ctrl) begin
                ctrl <= wctrl;
                if (wctrl.en && bad_setup(wctrl.unit, src[1:0], dst[1:0], cnt)) begin
                    ctrl.en <= 1'b0;
                    err     <= 1'b1;
                end
            end else if (step) begin
                src <= src + A_W'(sz);
                dst <= dst + A_W'(sz);
                cnt <= cnt - sz;
                if (last) begin
                    ctrl.en <= 1'b0;
                    done    <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dma2_arb.sv
module dma2_arb
    import dma2_pkg::*;
(
    input  logic [NCH-1:0] ready,
    input  logic           hi_sel,
    output logic           any,
    output logic           pick
);
    assign any = |ready;

    always_comb begin
        if (hi_sel) pick = ready[1] ? 1'b1 : 1'b0;
        else        pick = ready[0] ? 1'b0 : 1'b1;
    end
endmodule

// File: rtl/dma2_xfer.sv
module dma2_xfer
    import dma2_pkg::*;
#(
    parameter int A_W = AW,
    parameter int D_W = DW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           any,
    input  logic           pick,
    input  logic           bus_gnt,
    input  logic [D_W-1:0] bus_rdata,
    input  logic [A_W-1:0] c_src,
    input  logic [A_W-1:0] c_dst,
    input  unit_e          c_unit,
    input  logic           c_burst,
    input  logic           c_single,
    input  logic           c_dir,
    input  logic           c_last,
    output logic           cur,
    output logic           bus_req,
    output logic           bus_valid,
    output logic           bus_write,
    output logic [A_W-1:0] bus_addr,
    output logic [D_W-1:0] bus_wdata,
    output logic [1:0]     bus_size,
    output logic           unit_done
);
    st_e            st;
    logic [D_W-1:0] hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            cur  <= 1'b0;
            hold <= '0;
        end else begin
            case (st)
                ST_IDLE: if (any) begin
                    cur <= pick;
                    st  <= ST_REQ;
                end
                ST_REQ: if (bus_gnt) st <= c_single ? ST_ONE : ST_RD;
                ST_RD: begin
                    hold <= bus_rdata;
                    st   <= ST_WR;
                end
                ST_WR, ST_ONE: begin
                    if (c_burst && !c_last) st <= c_single ? ST_ONE : ST_RD;
                    else                    st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        bus_req   = (st != ST_IDLE);
        bus_valid = (st == ST_RD) || (st == ST_WR) || (st == ST_ONE);
        bus_write = (st == ST_WR) || ((st == ST_ONE) && c_dir);
        unit_done = (st == ST_WR) || (st == ST_ONE);
        bus_size  = c_unit;
        bus_wdata = (st == ST_WR) ? hold : '0;
        case (st)
            ST_RD:   bus_addr = c_src;
            ST_WR:   bus_addr = c_dst;
            ST_ONE:  bus_addr = c_dir ? c_dst : c_src;
            default: bus_addr = '0;
        endcase
    end
endmodule

// File: rtl/dma2_top.sv
module dma2_top
    import dma2_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           reg_we,
    input  logic [3:0]     reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata,
    output logic           bus_req,
    input  logic           bus_gnt,
    output logic           bus_valid,
    output logic           bus_write,
    output logic [AW-1:0]  bus_addr,
    output logic [1:0]     bus_size,
    output logic [DW-1:0]  bus_wdata,
    input  logic [DW-1:0]  bus_rdata,
    input  logic [NCH-1:0] dreq,
    output logic [NCH-1:0] dack,
    output logic [NCH-1:0] irq
);
    localparam logic [2:0] F_SRC = 3'd0, F_DST = 3'd1, F_CNT = 3'd2,
                           F_CTL = 3'd3, F_GLB = 3'd4;

    logic [2:0]     fld;
    logic           rch;
    logic           hi_sel;
    logic           any, pick, cur, unit_done;
    logic [AW-1:0]  src_a [NCH];
    logic [AW-1:0]  dst_a [NCH];
    logic [CW-1:0]  cnt_a [NCH];
    ctrl_t          ctl_a [NCH];
    logic [NCH-1:0] ready_v, last_v, done_v, err_v;
    ctrl_t          cur_ctrl;
    logic           cur_last, cur_burst;

    assign fld = reg_addr[2:0];
    assign rch = reg_addr[3];

    always_ff @(posedge clk) begin
        if (rst)                        hi_sel <= 1'b0;
        else if (reg_we && fld == F_GLB) hi_sel <= reg_wdata[0];
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic sel;
        assign sel = reg_we && (rch == 1'(i));
        dma2_chan u_chan (
            .clk     (clk),
            .rst     (rst),
            .wr_src  (sel && fld == F_SRC),
            .wr_dst  (sel && fld == F_DST),
            .wr_cnt  (sel && fld == F_CNT),
            .wr_ctrl (sel && fld == F_CTL),
            .wdata   (reg_wdata),
            .clr_done(reg_we && fld == F_GLB && reg_wdata[8+i]),
            .clr_err (reg_we && fld == F_GLB && reg_wdata[10+i]),
            .dreq    (dreq[i]),
            .step    (unit_done && cur == 1'(i)),
            .src     (src_a[i]),
            .dst     (dst_a[i]),
            .cnt     (cnt_a[i]),
            .ctrl    (ctl_a[i]),
            .ready   (ready_v[i]),
            .last    (last_v[i]),
            .done    (done_v[i]),
            .err     (err_v[i])
        );
        assign dack[i] = bus_valid && (cur == 1'(i));
        assign irq[i]  = done_v[i];
    end

    dma2_arb u_arb (
        .ready (ready_v),
        .hi_sel(hi_sel),
        .any   (any),
        .pick  (pick)
    );

    assign cur_ctrl  = ctl_a[cur];
    assign cur_last  = last_v[cur];
    assign cur_burst = cur_ctrl.burst;

    dma2_xfer u_xfer (
        .clk      (clk),
        .rst      (rst),
        .any      (any),
        .pick     (pick),
        .bus_gnt  (bus_gnt),
        .bus_rdata(bus_rdata),
        .c_src    (src_a[cur]),
        .c_dst    (dst_a[cur]),
        .c_unit   (cur_ctrl.unit),
        .c_burst  (cur_ctrl.burst),
        .c_single (cur_ctrl.single),
        .c_dir    (cur_ctrl.dir),
        .c_last   (cur_last),
        .cur      (cur),
        .bus_req  (bus_req),
        .bus_valid(bus_valid),
        .bus_write(bus_write),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_size (bus_size),
        .unit_done(unit_done)
    );

    always_comb begin
        case (fld)
            F_SRC:   reg_rdata = src_a[rch];
            F_DST:   reg_rdata = dst_a[rch];
            F_CNT:   reg_rdata = {{(DW-CW){1'b0}}, cnt_a[rch]};
            F_CTL:   reg_rdata = {{(DW-$bits(ctrl_t)){1'b0}}, ctl_a[rch]};
            F_GLB:   reg_rdata = {20'b0, err_v, done_v, 7'b0, hi_sel};
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dma2_chk.sv
module dma2_chk (
    input logic        clk,
    input logic        rst,
    input logic        bus_req,
    input logic        bus_valid,
    input logic [31:0] bus_addr,
    input logic [1:0]  bus_size,
    input logic [1:0]  dack,
    input logic [1:0]  irq,
    input logic        unit_done,
    input logic        cur_burst,
    input logic        cur_last
);
    // R1
    valid_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        bus_valid |-> bus_req);

    // R12
    dack_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dack));

    // R12
    dack_in_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (|dack) |-> bus_valid);

    // R11
    word_align_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_size == 2'd2) |-> (bus_addr[1:0] == 2'b00));

    // R11
    half_align_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_size == 2'd1) |-> (bus_addr[0] == 1'b0));

    // R6
    burst_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (unit_done && cur_burst && !cur_last) |=> bus_req);

    // R7
    steal_release_chk: assert property (@(posedge clk) disable iff (rst)
        (unit_done && !cur_burst) |=> !bus_req);

    // R10
    irq0_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq[0]) |-> $past(unit_done));

    // R10
    irq1_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq[1]) |-> $past(unit_done));
endmodule

bind dma2_top dma2_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_req  (bus_req),
    .bus_valid(bus_valid),
    .bus_addr (bus_addr),
    .bus_size (bus_size),
    .dack     (dack),
    .irq      (irq),
    .unit_done(unit_done),
    .cur_burst(cur_burst),
    .cur_last (cur_last)
);

// File: tb/dma2_top_test.sv
`timescale 1ns/1ps
module dma2_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        bus_req, bus_gnt, bus_valid, bus_write;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;
    logic [1:0]  bus_size;
    logic [1:0]  dreq = 2'b00;
    logic [1:0]  dack, irq;
    logic        gnt_en = 1'b1;

    int checks = 0;
    int errors = 0;
    int req_falls = 0;
    logic req_prev = 1'b0;
    int cyc = 0;

    typedef struct {
        logic [31:0] addr;
        logic        wr;
        logic        dchk;
        logic [31:0] data;
        logic [1:0]  size;
        int          ch;
        string       tag;
    } item_t;
    item_t q[$];

    always #2.5 clk = ~clk;

    dma2_top uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_req(bus_req),
        .bus_gnt(bus_gnt), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .dreq(dreq), .dack(dack), .irq(irq)
    );

    function automatic logic [31:0] pat(logic [31:0] a, logic [1:0] s);
        logic [31:0] v;
        v = {a[15:0] ^ 16'hC3A5, ~a[15:0]};
        if (s == 2'd0) return v & 32'hFF;
        if (s == 2'd1) return v & 32'hFFFF;
        return v;
    endfunction

    assign bus_rdata = pat(bus_addr, bus_size);

    always @(posedge clk) begin
        if (rst) bus_gnt <= 1'b0;
        else     bus_gnt <= bus_req & gnt_en;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pops the expected bus cycles as the engine issues them
    always @(negedge clk) begin : mon
        item_t e;
        if (!rst) begin
            if (req_prev && !bus_req) req_falls++;
            req_prev = bus_req;
            if (bus_valid) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R3 unexpected bus cycle", bus_addr, 32'h0);
                end else begin
                    e = q.pop_front();
                    chk(bus_addr == e.addr, {e.tag, " address"}, bus_addr, e.addr);
                    chk(bus_write == e.wr && bus_size == e.size,
                        {e.tag, " write/size"}, {29'b0, bus_write, bus_size},
                        {29'b0, e.wr, e.size});
                    chk(dack == (2'b01 << e.ch), {e.tag, " R12 dack"},
                        {30'b0, dack}, {30'b0, 2'b01 << e.ch});
                    if (e.dchk)
                        chk(bus_wdata == e.data, {e.tag, " data"}, bus_wdata, e.data);
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic logic [31:0] cw(bit en, logic [1:0] u, bit burst, bit single,
                                       bit autor, bit dir);
        return {25'b0, dir, autor, single, burst, u, en};
    endfunction

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic setup(input int ch, input logic [31:0] s, input logic [31:0] d,
                         input logic [31:0] n);
        wr({ch[0], 3'd0}, s);
        wr({ch[0], 3'd1}, d);
        wr({ch[0], 3'd2}, n);
    endtask

    task automatic push(input int ch, input logic [31:0] a, input bit w, input bit dc,
                        input logic [31:0] d, input logic [1:0] u, input string tag);
        item_t e;
        e.addr = a; e.wr = w; e.dchk = dc; e.data = d; e.size = u; e.ch = ch; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic plan_dual(input int ch, input logic [31:0] s, input logic [31:0] d,
                             input int n, input logic [1:0] u, input string tag);
        int sz;
        sz = 1 << u;
        for (int k = 0; k < n / sz; k++) begin
            push(ch, s + k * sz, 1'b0, 1'b0, 32'h0, u, tag);
            push(ch, d + k * sz, 1'b1, 1'b1, pat(s + k * sz, u), u, tag);
        end
    endtask

    task automatic plan_single(input int ch, input logic [31:0] base, input int n,
                               input logic [1:0] u, input bit dir, input string tag);
        int sz;
        sz = 1 << u;
        for (int k = 0; k < n / sz; k++)
            push(ch, base + k * sz, dir, 1'b0, 32'h0, u, tag);
    endtask

    task automatic wait_irq(input int ch, input string tag);
        int n;
        n = 0;
        while (!irq[ch] && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk(irq[ch] == 1'b1, tag, {30'b0, irq}, 32'h1 << ch);
    endtask

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(4'h4, v);
        chk(v == 32'h0 && !bus_req && !bus_valid && dack == 2'b00 && irq == 2'b00,
            "R1 reset state", v, 32'h0);
        // R2 19-bit count holds the maximum
        wr(4'hA, 32'h0004_0000);
        rd(4'hA, v);
        chk(v == 32'h0004_0000, "R2 count width", v, 32'h0004_0000);

        // R3 R4 R6 dual-address word burst, auto-request, channel 0
        setup(0, 32'h1000, 32'h2000, 16);
        plan_dual(0, 32'h1000, 32'h2000, 16, 2'd2, "R3 word burst");
        req_falls = 0;
        wr(4'h3, cw(1, 2'd2, 1, 0, 1, 0));
        wait_irq(0, "R10 irq ch0");
        repeat (3) @(negedge clk);
        chk(req_falls == 1, "R6 one bus release", req_falls, 1);
        rd(4'h0, v);
        chk(v == 32'h1010, "R4 source stepped by 4", v, 32'h1010);
        rd(4'h2, v);
        chk(v == 32'h0, "R4 count consumed", v, 32'h0);
        rd(4'h3, v);
        chk(v == 32'h2C, "R10 enable cleared", v, 32'h2C);
        rd(4'h4, v);
        chk(v == 32'h100, "R10 done flag ch0", v, 32'h100);
        wr(4'h4, 32'h100);
        rd(4'h4, v);
        chk(v == 32'h0 && irq == 2'b00, "R10 done clear", v, 32'h0);

        // R4 R7 dual-address half-word cycle steal, channel 1
        setup(1, 32'h3002, 32'h4000, 6);
        plan_dual(1, 32'h3002, 32'h4000, 6, 2'd1, "R4 half steal");
        req_falls = 0;
        wr(4'hB, cw(1, 2'd1, 0, 0, 1, 0));
        wait_irq(1, "R10 irq ch1");
        repeat (3) @(negedge clk);
        chk(req_falls == 3, "R7 release per unit", req_falls, 3);
        rd(4'h9, v);
        chk(v == 32'h4006, "R4 destination stepped by 2", v, 32'h4006);
        wr(4'h4, 32'h200);

        // R5 single-address byte read, burst, channel 0
        setup(0, 32'h5001, 32'h0, 3);
        plan_single(0, 32'h5001, 3, 2'd0, 1'b0, "R5 fly-by read");
        req_falls = 0;
        wr(4'h3, cw(1, 2'd0, 1, 1, 1, 0));
        wait_irq(0, "R5 irq");
        repeat (3) @(negedge clk);
        chk(req_falls == 1, "R6 single burst one release", req_falls, 1);
        wr(4'h4, 32'h100);

        // R5 single-address half-word write, cycle steal, channel 1
        setup(1, 32'h0, 32'h6000, 4);
        plan_single(1, 32'h6000, 4, 2'd1, 1'b1, "R5 fly-by write");
        wr(4'hB, cw(1, 2'd1, 0, 1, 1, 1));
        wait_irq(1, "R5 irq");
        wr(4'h4, 32'h200);

        // R8 external request gates the channel
        setup(1, 32'hA000, 32'hB000, 8);
        plan_dual(1, 32'hA000, 32'hB000, 8, 2'd2, "R8 ext request");
        wr(4'hB, cw(1, 2'd2, 0, 0, 0, 0));
        repeat (20) @(negedge clk);
        chk(!bus_req && q.size() == 4, "R8 idle without dreq", {31'b0, bus_req}, 32'h0);
        dreq = 2'b10;
        wait_irq(1, "R8 irq after dreq");
        dreq = 2'b00;
        wr(4'h4, 32'h200);

        // R9 channel 0 first
        setup(0, 32'h8000, 32'h8100, 2);
        setup(1, 32'h9000, 32'h9100, 2);
        plan_dual(0, 32'h8000, 32'h8100, 2, 2'd0, "R9 ch0 high");
        plan_dual(1, 32'h9000, 32'h9100, 2, 2'd0, "R9 ch0 high");
        wr(4'h3, cw(1, 2'd0, 0, 0, 0, 0));
        wr(4'hB, cw(1, 2'd0, 0, 0, 0, 0));
        @(negedge clk);
        dreq = 2'b11;
        wait_irq(0, "R9 ch0 done");
        wait_irq(1, "R9 ch1 done");
        dreq = 2'b00;
        wr(4'h4, 32'h301);

        // R9 channel 1 first
        setup(0, 32'h8200, 32'h8300, 2);
        setup(1, 32'h9200, 32'h9300, 2);
        plan_dual(1, 32'h9200, 32'h9300, 2, 2'd0, "R9 ch1 high");
        plan_dual(0, 32'h8200, 32'h8300, 2, 2'd0, "R9 ch1 high");
        wr(4'h3, cw(1, 2'd0, 0, 0, 0, 0));
        wr(4'hB, cw(1, 2'd0, 0, 0, 0, 0));
        @(negedge clk);
        dreq = 2'b11;
        wait_irq(0, "R9 ch0 done");
        wait_irq(1, "R9 ch1 done");
        dreq = 2'b00;
        wr(4'h4, 32'h300);

        // R11 misaligned word source
        setup(0, 32'h7002, 32'h7100, 8);
        wr(4'h3, cw(1, 2'd2, 1, 0, 1, 0));
        repeat (10) @(negedge clk);
        chk(!bus_req, "R11 no start when misaligned", {31'b0, bus_req}, 32'h0);
        rd(4'h4, v);
        chk(v == 32'h400, "R11 error flag ch0", v, 32'h400);
        rd(4'h3, v);
        chk(v[0] == 1'b0, "R11 enable refused", v, 32'h2C);
        // R11 zero count
        setup(1, 32'h0, 32'h0, 0);
        wr(4'hB, cw(1, 2'd0, 1, 0, 1, 0));
        rd(4'h4, v);
        chk(v == 32'hC00, "R11 zero count error ch1", v, 32'hC00);
        wr(4'h4, 32'hC00);
        // R11 count above the maximum
        setup(0, 32'h0, 32'h0, 32'h0004_0004);
        wr(4'h3, cw(1, 2'd2, 1, 0, 1, 0));
        repeat (5) @(negedge clk);
        rd(4'h4, v);
        chk(v == 32'h400 && !bus_req, "R11 oversize count", v, 32'h400);
        wr(4'h4, 32'h400);
        rd(4'h4, v);
        chk(v == 32'h0, "R11 error clear", v, 32'h0);

        chk(q.size() == 0, "R3 all expected cycles issued", q.size(), 32'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule